// File: doc/BRIEF.md
# Binary Berlekamp-Massey Error Locator Solver

This block turns the 2t syndromes of a binary BCH codeword into the error locator polynomial sigma(x) and its degree. Because the code is binary, every even syndrome is the square of an odd one. The solver therefore uses the shortened form of the Berlekamp iteration: it runs t steps instead of 2t, and each step evaluates one odd-indexed discrepancy. A table inside the block keeps, for every step, a candidate polynomial, its discrepancy, its order and its delta. Each step looks back through this table to find the reference row it needs.

A host pulses `start_i` with the correction capability `t_i` and the syndromes on `synd_i`. The block then performs one iteration per clock. When it has a result, it raises `done_o` and holds `sigma_o` and `degree_o` until the next accepted start. If the discrepancy stays zero for long enough, the iteration stops early. Field arithmetic is in GF(2^M), by default GF(2^5) with the reduction polynomial x^5+x^2+1 and primitive element alpha = 2. Division is done as a multiplication by a field inverse, which an internal inverse unit computes.

Top module: `bm_locator_solver`

## Requirements
- R1: A start pulse seen while idle or finished captures the clamped t and all syndromes, and seeds the table. Row 0 gets sigma = 1, discrepancy 1, order 0 and mu = -1. Row 1 gets sigma = 1, discrepancy S1, order 0 and mu = 0. On the clock after the capture edge `done_o` is low.
- R2: Iteration i (i = 1..t) takes one clock and gives row i+1 the value mu = 2i. The result appears no later than t clocks after the capture edge.
- R3: When the discrepancy d_i is nonzero, the block picks a reference row ro. This is the earliest row below i that has a nonzero discrepancy and the strictly largest delta = mu - order; it is row 0 if no row qualifies. With diff = mu_i - mu_ro, the new polynomial is sigma_i + (d_i * inv(d_ro)) x^diff sigma_ro. The new order is max(order_i, order_ro + diff).
- R4: When the discrepancy d_i is zero, row i+1 copies the polynomial and order of row i, and a zero-discrepancy counter increments.
- R5: Let v = t - order_i - 1. If that counter reaches v/2 + 2 when v is odd, or v/2 + 1 when v is even (2 when v < 0), row i is the result and the run ends at once. With all-zero syndromes this ends the run after 3 clocks for t = 4 and after 2 clocks for t = 3.
- R6: Before every iteration except the last, the next discrepancy is computed as S(2i+1) plus the sum over k >= 1 of sigma(i+1),k times S(2i+1-k). Without an early exit, row t+1 is the result.
- R7: Syndrome S_k sits at `synd_i[(k-1)*M +: M]`, and the coefficient of x^k sits at `sigma_o[k*M +: M]`. For at most t bit errors at positions p, sigma_o equals the product of (1 + alpha^p x) and `degree_o` equals the number of errors.
- R8: After `done_o` rises, `done_o`, `sigma_o` and `degree_o` hold their values while `synd_i` and `t_i` change, until the next accepted start.
- R9: A start pulse during a run is ignored, and the run finishes with the result of the original inputs.
- R10: A t of 0 is treated as 1, and a t above MAX_T is treated as MAX_T.
- R11: After reset `done_o` is low and `sigma_o` and `degree_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| t_i | input | $clog2(MAX_T+1) | Correction capability t |
| synd_i | input | 2*MAX_T*M | Syndromes S1..S2t, S1 in the low bits |
| done_o | output | 1 | Result valid and held |
| sigma_o | output | (MAX_T+1)*M | Locator coefficients, x^0 in the low bits |
| degree_o | output | $clog2(2*MAX_T+2)+1 | Degree of sigma(x) |

## Verification
On every cycle, the assertions check the protocol-level behaviour. A seeded row 1 must carry S1. A zero-discrepancy step must copy the previous row. The order must never fall from one row to the next. Iteration t must always end the run, starts during a run must leave the captured inputs alone, and the result must hold after done. Only the bench's scenarios show that the algebra is right. The bench builds syndromes from chosen error positions and compares sigma against the product of the error locators. It also shows the exact early-exit latencies, the clamping of t and the dropping of a start that arrives mid-run.

// File: rtl/bm_pkg.sv
package bm_pkg;

    // Default field: GF(2^5), x^5 + x^2 + 1
    localparam int GF_M_DEF    = 5;
    localparam int GF_POLY_DEF = 'h25;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } bm_state_e;

endpackage

// File: rtl/bm_gf_inverse.sv
// Field inverse by exponentiation: a^(2^M - 2); zero maps to zero.
module bm_gf_inverse #(
    parameter int M    = 5,
    parameter int POLY = 'h25
) (
    input  logic [M-1:0] val_i,
    output logic [M-1:0] inv_o
);
    localparam logic [M-1:0] RED = M'(POLY);

    function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] acc;
        acc = '0;
        for (int k = M - 1; k >= 0; k--) begin
            acc = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? RED : '0);
            if (b[k]) acc = acc ^ a;
        end
        return acc;
    endfunction

    always_comb begin
        logic [M-1:0] sq;
        logic [M-1:0] prod;
        sq   = fmul(val_i, val_i);
        prod = sq;
        for (int k = 2; k < M; k++) begin
            sq   = fmul(sq, sq);
            prod = fmul(prod, sq);
        end
        inv_o = prod;
    end
endmodule

// File: rtl/bm_ref_pick.sv
// Chooses the reference row: nonzero discrepancy, strictly largest delta,
// earliest on ties, row 0 by default.
module bm_ref_pick #(
    parameter int ROWS = 6,
    parameter int M    = 5,
    parameter int IW   = 6,
    parameter int RW   = 3
) (
    input  logic [ROWS-1:0][M-1:0]  dsc_i,
    input  logic [ROWS-1:0][IW-1:0] dlt_i,
    input  logic [RW-1:0]           cur_i,
    output logic [RW-1:0]           ref_o
);
    always_comb begin
        logic signed [IW-1:0] best;
        best  = '1;
        ref_o = '0;
        for (int j = 0; j < ROWS; j++) begin
            if (j < int'(cur_i) && dsc_i[j] != '0 && $signed(dlt_i[j]) > best) begin
                best  = $signed(dlt_i[j]);
                ref_o = RW'(j);
            end
        end
    end
endmodule

// File: rtl/bm_row_update.sv
// Builds the next table row (copy or correction) and its discrepancy.
module bm_row_update #(
    parameter int M    = 5,
    parameter int POLY = 'h25,
    parameter int NC   = 5,
    parameter int NS   = 8,
    parameter int LW   = 5,
    parameter int RW   = 3
) (
    input  logic                   copy_i,
    input  logic [NC-1:0][M-1:0]   sig_cur_i,
    input  logic [LW-1:0]          ord_cur_i,
    input  logic [M-1:0]           dsc_cur_i,
    input  logic [NC-1:0][M-1:0]   sig_ref_i,
    input  logic [LW-1:0]          ord_ref_i,
    input  logic [M-1:0]           ref_inv_i,
    input  logic [LW-1:0]          diff_i,
    input  logic [NS-1:0][M-1:0]   syn_i,
    input  logic [RW-1:0]          it_i,
    output logic [NC-1:0][M-1:0]   sig_nxt_o,
    output logic [LW-1:0]          ord_nxt_o,
    output logic [M-1:0]           dsc_nxt_o
);
    localparam logic [M-1:0] RED = M'(POLY);

    function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] acc;
        acc = '0;
        for (int k = M - 1; k >= 0; k--) begin
            acc = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? RED : '0);
            if (b[k]) acc = acc ^ a;
        end
        return acc;
    endfunction

    // Next polynomial and order
    always_comb begin
        logic [M-1:0]  scale;
        logic [LW-1:0] reach;
        scale = fmul(dsc_cur_i, ref_inv_i);
        reach = ord_ref_i + diff_i;
        for (int k = 0; k < NC; k++) begin
            sig_nxt_o[k] = sig_cur_i[k];
            if (!copy_i) begin
                for (int j = 0; j < NC; j++) begin
                    if (j + int'(diff_i) == k)
                        sig_nxt_o[k] = sig_nxt_o[k] ^ fmul(scale, sig_ref_i[j]);
                end
            end
        end
        if (copy_i || ord_cur_i > reach)
            ord_nxt_o = ord_cur_i;
        else
            ord_nxt_o = reach;
    end

    // Next odd discrepancy: S(2i+1) + sum_k sigma_k * S(2i+1-k)
    always_comb begin
        int           two_i;
        logic [M-1:0] opnd;
        two_i     = 2 * int'(it_i);
        dsc_nxt_o = '0;
        for (int n = 0; n < NS; n++) begin
            if (n == two_i) dsc_nxt_o = dsc_nxt_o ^ syn_i[n];
        end
        for (int k = 1; k < NC; k++) begin
            opnd = '0;
            for (int n = 0; n < NS; n++) begin
                if (n + k == two_i) opnd = syn_i[n];
            end
            dsc_nxt_o = dsc_nxt_o ^ fmul(sig_nxt_o[k], opnd);
        end
    end
endmodule

// File: rtl/bm_locator_solver.sv
module bm_locator_solver
    import bm_pkg::*;
#(
    parameter  int M     = GF_M_DEF,
    parameter  int POLY  = GF_POLY_DEF,
    parameter  int MAX_T = 4,
    localparam int NC    = MAX_T + 1,
    localparam int NS    = 2 * MAX_T,
    localparam int ROWS  = MAX_T + 2,
    localparam int RW    = $clog2(ROWS + 1),
    localparam int TW    = $clog2(MAX_T + 1),
    localparam int LW    = $clog2(2 * MAX_T + 2) + 1,
    localparam int IW    = LW + 1,
    localparam int CW    = RW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [TW-1:0]       t_i,
    input  logic [NS*M-1:0]     synd_i,
    output logic                done_o,
    output logic [NC*M-1:0]     sigma_o,
    output logic [LW-1:0]       degree_o
);

    typedef struct packed {
        bm_state_e                     st;
        logic [TW-1:0]                 t;
        logic [RW-1:0]                 i;
        logic [CW-1:0]                 zcnt;
        logic [NS-1:0][M-1:0]          syn;
        logic [ROWS-1:0][NC-1:0][M-1:0] sig;
        logic [ROWS-1:0][M-1:0]        dsc;
        logic [ROWS-1:0][LW-1:0]       ord;
        logic [ROWS-1:0][IW-1:0]       dlt;
        logic [NC-1:0][M-1:0]          res;
        logic [LW-1:0]                 deg;
        logic                          done;
    } bm_reg_t;

    bm_reg_t r_q, r_d;

    logic [RW-1:0]         ref_w, nxt_w;
    logic [NC-1:0][M-1:0]  sig_cur_w, sig_ref_w, sig_nxt_w;
    logic [LW-1:0]         ord_cur_w, ord_ref_w, ord_nxt_w, diff_w;
    logic [M-1:0]          dsc_cur_w, ref_inv_w, dsc_nxt_w;
    logic [TW-1:0]         t_eff_w;

    assign nxt_w     = r_q.i + RW'(1);
    assign sig_cur_w = r_q.sig[r_q.i];
    assign ord_cur_w = r_q.ord[r_q.i];
    assign dsc_cur_w = r_q.dsc[r_q.i];
    assign sig_ref_w = r_q.sig[ref_w];
    assign ord_ref_w = r_q.ord[ref_w];
    // mu(0) = -1, mu(j) = 2(j-1) otherwise
    assign diff_w    = (ref_w == '0) ? LW'(2 * int'(r_q.i) - 1)
                                     : LW'(2 * (int'(r_q.i) - int'(ref_w)));
    assign t_eff_w   = (t_i == '0) ? TW'(1)
                     : ((int'(t_i) > MAX_T) ? TW'(MAX_T) : t_i);

    bm_ref_pick #(.ROWS(ROWS), .M(M), .IW(IW), .RW(RW)) u_pick (
        .dsc_i (r_q.dsc),
        .dlt_i (r_q.dlt),
        .cur_i (r_q.i),
        .ref_o (ref_w)
    );

    bm_gf_inverse #(.M(M), .POLY(POLY)) u_inv (
        .val_i (r_q.dsc[ref_w]),
        .inv_o (ref_inv_w)
    );

    bm_row_update #(.M(M), .POLY(POLY), .NC(NC), .NS(NS), .LW(LW), .RW(RW)) u_upd (
        .copy_i    (dsc_cur_w == '0),
        .sig_cur_i (sig_cur_w),
        .ord_cur_i (ord_cur_w),
        .dsc_cur_i (dsc_cur_w),
        .sig_ref_i (sig_ref_w),
        .ord_ref_i (ord_ref_w),
        .ref_inv_i (ref_inv_w),
        .diff_i    (diff_w),
        .syn_i     (r_q.syn),
        .it_i      (r_q.i),
        .sig_nxt_o (sig_nxt_w),
        .ord_nxt_o (ord_nxt_w),
        .dsc_nxt_o (dsc_nxt_w)
    );

    always_comb begin
        int v_rem;
        int thr;
        int zn;
        r_d   = r_q;
        v_rem = int'(r_q.t) - int'(ord_cur_w) - 1;
        if (v_rem < 0)
            thr = 2;
        else
            thr = v_rem / 2 + (((v_rem % 2) != 0) ? 2 : 1);
        zn = int'(r_q.zcnt) + 1;

        case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    r_d.st        = ST_RUN;
                    r_d.t         = t_eff_w;
                    r_d.i         = RW'(1);
                    r_d.zcnt      = '0;
                    r_d.syn       = synd_i;
                    r_d.sig       = '0;
                    r_d.dsc       = '0;
                    r_d.ord       = '0;
                    r_d.dlt       = '0;
                    r_d.sig[0][0] = M'(1);
                    r_d.sig[1][0] = M'(1);
                    r_d.dsc[0]    = M'(1);
                    r_d.dsc[1]    = synd_i[M-1:0];
                    r_d.dlt[0]    = '1;
                    r_d.res       = '0;
                    r_d.deg       = '0;
                    r_d.done      = 1'b0;
                end
            end
            ST_RUN: begin
                if (dsc_cur_w == '0) r_d.zcnt = CW'(zn);
                if (dsc_cur_w == '0 && zn == thr) begin
                    r_d.res  = sig_cur_w;
                    r_d.deg  = ord_cur_w;
                    r_d.done = 1'b1;
                    r_d.st   = ST_DONE;
                end else begin
                    r_d.sig[nxt_w] = sig_nxt_w;
                    r_d.ord[nxt_w] = ord_nxt_w;
                    r_d.dlt[nxt_w] = IW'(2 * int'(r_q.i) - int'(ord_nxt_w));
                    if (int'(r_q.i) == int'(r_q.t)) begin
                        r_d.res  = sig_nxt_w;
                        r_d.deg  = ord_nxt_w;
                        r_d.done = 1'b1;
                        r_d.st   = ST_DONE;
                    end else begin
                        r_d.dsc[nxt_w] = dsc_nxt_w;
                        r_d.i          = nxt_w;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o   = r_q.done;
    assign sigma_o  = r_q.res;
    assign degree_o = r_q.deg;

    // R1: seeding on an accepted start
    a_r1_row_seed: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_RUN && start_i) |=>
            (!done_o && r_q.st == ST_RUN && r_q.i == RW'(1) && r_q.dsc[1] == $past(synd_i[M-1:0])));

    // R2: iteration t always ends the run
    a_r2_last_iteration: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && int'(r_q.i) == int'(r_q.t)) |=> done_o);

    // R3: order never decreases along the table
    a_r3_order_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && r_q.i > RW'(1)) |-> (r_q.ord[r_q.i] >= r_q.ord[r_q.i - RW'(1)]));

    // R4: zero discrepancy copies the row forward
    a_r4_zero_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && r_q.dsc[r_q.i] == '0) |=>
            (done_o || (r_q.ord[r_q.i] == $past(r_q.ord[r_q.i]) &&
                        r_q.sig[r_q.i] == $past(r_q.sig[r_q.i]))));

    // R8: result held after done
    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(sigma_o) && $stable(degree_o)));

    // R9: start during a run leaves captured inputs alone
    a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && start_i) |=> (r_q.t == $past(r_q.t) && r_q.syn == $past(r_q.syn)));

endmodule

// File: tb/sim_bm_locator_solver.sv
module sim_bm_locator_solver;
    localparam int M  = 5;
    localparam int MT = 4;
    localparam int NC = MT + 1;
    localparam int NS = 2 * MT;
    localparam int TW = $clog2(MT + 1);
    localparam int LW = $clog2(2 * MT + 2) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [TW-1:0]   t_in = '0;
    logic [NS*M-1:0] syn = '0;
    logic            done;
    logic [NC*M-1:0] sig;
    logic [LW-1:0]   deg;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bm_locator_solver #(.M(M), .POLY('h25), .MAX_T(MT)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .t_i(t_in), .synd_i(syn),
        .done_o(done), .sigma_o(sig), .degree_o(deg)
    );

    typedef struct packed {
        logic [2:0]      t;
        logic [2:0]      n;
        logic [3:0][4:0] pos;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{3'd4, 3'd0, {5'd0,  5'd0,  5'd0,  5'd0 }},
        '{3'd4, 3'd1, {5'd0,  5'd0,  5'd0,  5'd5 }},
        '{3'd4, 3'd2, {5'd0,  5'd0,  5'd17, 5'd0 }},
        '{3'd4, 3'd3, {5'd0,  5'd29, 5'd11, 5'd3 }},
        '{3'd4, 3'd4, {5'd30, 5'd20, 5'd7,  5'd1 }},
        '{3'd3, 3'd3, {5'd0,  5'd8,  5'd4,  5'd2 }},
        '{3'd2, 3'd2, {5'd0,  5'd0,  5'd25, 5'd10}},
        '{3'd1, 3'd1, {5'd0,  5'd0,  5'd0,  5'd14}},
        '{3'd2, 3'd1, {5'd0,  5'd0,  5'd0,  5'd30}},
        '{3'd3, 3'd2, {5'd0,  5'd0,  5'd19, 5'd6 }},
        '{3'd4, 3'd4, {5'd3,  5'd2,  5'd1,  5'd0 }},
        '{3'd3, 3'd0, {5'd0,  5'd0,  5'd0,  5'd0 }}
    };

    function automatic logic [4:0] bmul(input logic [4:0] a, input logic [4:0] b);
        logic [9:0] p;
        p = '0;
        for (int k = 0; k < 5; k++) if (b[k]) p = p ^ ({5'd0, a} << k);
        for (int k = 9; k >= 5; k--) if (p[k]) p = p ^ (10'h025 << (k - 5));
        return p[4:0];
    endfunction

    function automatic logic [4:0] apow(input int e);
        logic [4:0] r;
        r = 5'd1;
        for (int k = 0; k < e % 31; k++) r = bmul(r, 5'd2);
        return r;
    endfunction

    task automatic build(input vec_t v, output logic [NS*M-1:0] sv,
                         output logic [NC*M-1:0] es, output logic [LW-1:0] ed);
        logic [4:0] c [NC];
        logic [4:0] x;
        sv = '0;
        for (int k = 1; k <= NS; k++) begin
            logic [4:0] s;
            s = '0;
            for (int e = 0; e < int'(v.n); e++) s = s ^ apow(k * int'(v.pos[e]));
            sv[(k-1)*M +: M] = s;
        end
        for (int j = 0; j < NC; j++) c[j] = '0;
        c[0] = 5'd1;
        for (int e = 0; e < int'(v.n); e++) begin
            x = apow(int'(v.pos[e]));
            for (int j = NC - 1; j >= 1; j--) c[j] = c[j] ^ bmul(x, c[j-1]);
        end
        es = '0;
        for (int j = 0; j < NC; j++) es[j*M +: M] = c[j];
        ed = LW'(v.n);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [TW-1:0] tv, input logic [NS*M-1:0] sv, output int lat);
        @(negedge clk);
        start = 1'b1; t_in = tv; syn = sv;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R1 done low after capture", 32'(done), 0);
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [NS*M-1:0] sv, sv_b;
        logic [NC*M-1:0] es, es_b;
        logic [LW-1:0]   ed, ed_b;
        int lat;

        // R11 reset state
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && sig == '0 && deg == '0, "R11 reset outputs", 32'(sig), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && sig == '0 && deg == '0, "R11 after release", 32'(sig), 0);

        // Vector table: R2 R3 R6 R7, early exit R4 R5
        for (int v = 0; v < 12; v++) begin
            build(VECS[v], sv, es, ed);
            run(TW'(VECS[v].t), sv, lat);
            chk(done == 1'b1, "R2 done raised", 32'(done), 1);
            chk(lat <= int'(VECS[v].t), "R2 latency bound", 32'(lat), 32'(VECS[v].t));
            chk(sig == es, "R3 R6 R7 sigma", 32'(sig), 32'(es));
            chk(deg == ed, "R7 degree", 32'(deg), 32'(ed));
            if (VECS[v].n == 3'd0) begin
                chk(lat == int'(VECS[v].t) - 1, "R4 R5 early exit latency", 32'(lat),
                    32'(int'(VECS[v].t) - 1));
            end
        end

        // R8 hold while inputs change without start
        build(VECS[4], sv, es, ed);
        run(3'd4, sv, lat);
        @(negedge clk);
        syn = ~sv; t_in = 3'd2;
        repeat (6) @(negedge clk);
        chk(done == 1'b1 && sig == es && deg == ed, "R8 result held", 32'(sig), 32'(es));

        // R9 start during a run ignored
        build(VECS[3], sv, es, ed);
        build(VECS[1], sv_b, es_b, ed_b);
        @(negedge clk);
        start = 1'b1; t_in = 3'd4; syn = sv;
        @(negedge clk);
        t_in = 3'd1; syn = sv_b;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(sig == es && deg == ed, "R9 busy start ignored", 32'(sig), 32'(es));

        // R10 clamp of t = 0 to 1
        build(VECS[7], sv, es, ed);
        run(3'd0, sv, lat);
        chk(done == 1'b1 && lat == 1, "R10 t zero runs one step", 32'(lat), 1);
        chk(sig == es, "R10 t zero sigma", 32'(sig), 32'(es));

        // R10 clamp of t = 7 to MAX_T
        build(VECS[4], sv, es, ed);
        run(3'd7, sv, lat);
        chk(done == 1'b1 && lat <= MT, "R10 large t bounded", 32'(lat), 32'(MT));
        chk(sig == es && deg == ed, "R10 large t sigma", 32'(sig), 32'(es));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule